// File: doc/BRIEF.md
# Direct-Mapped Cache with Switchable Victim Buffer

This block is a read-only, direct-mapped first-level cache. It has a small, fully-associative victim buffer beside it. Each line the cache displaces is kept in the buffer. A later cache miss searches every buffer entry at once before it asks the next-level memory for the line. When the buffer holds the line, the line moves back into the cache, and the line it displaces takes the freed buffer slot.

The buffer can be turned off by one configuration bit. When it is off, a miss goes to memory at once, with no search cycle. Software can therefore turn the buffer off for programs that gain nothing from it, and those programs pay no extra cycle on the miss path.

The default geometry is 8 Kbyte of cache in 16-byte lines, a 31-bit byte address space and four buffer entries (eight also supported). With that geometry each buffer entry keeps a 27-bit line address and 128 bits of data. Three counters track cache hits, buffer hits and memory requests.

Top module: `cvb_cache`

## Requirements
- R1: Reset sets the outputs and state as follows: req_ready=1, resp_valid=0, mem_req_valid=0, all three counters zero, every cache line invalid, every buffer entry invalid, buffer enabled. A first access after reset therefore misses and takes the enabled timing.
- R2: A request accepted in cycle 0 that hits the cache answers with resp_valid in cycle 1. It makes no memory request, whether the buffer is on or off.
- R3: With the buffer enabled, a miss in both the cache and the buffer behaves as follows. Cycle 1 is the buffer search. mem_req_valid rises in cycle 2, with mem_req_laddr equal to byte-address bits [30:4]. The response comes in the cycle after mem_fill_valid, which gives cycle 22 with a 19-cycle memory.
- R4: With the buffer disabled, a miss skips the search cycle. mem_req_valid rises in cycle 1 and the response comes in cycle 21 with a 19-cycle memory.
- R5: A buffer hit answers in cycle 2 with no memory request. The requested line enters the cache. The cache line it displaces takes the same buffer slot, so it can be found there on a later miss.
- R6: While the buffer is enabled, a memory fill that displaces a valid cache line writes that line into the buffer.
- R7: Buffer insertions take slots in round-robin order, so a full buffer overwrites its oldest inserted entry. A swap never moves the insertion pointer.
- R8: A configuration write with cfg_vb_en=0 invalidates every buffer entry.
- R9: Lines displaced while the buffer is disabled are dropped. They miss to memory after the buffer is re-enabled.
- R10: cnt_cache_hit, cnt_vb_hit and cnt_mem each rise by exactly one per cache hit, buffer hit and memory request respectively.
- R11: req_ready is low from the cycle after a missing request is accepted until its response is given.
- R12: req_waddr carries byte-address bits [30:2]. Byte-address bits [3:2] select the returned 32-bit word, and word k sits at line bits [32k+31:32k].
- R13: mem_req_valid is high for exactly one cycle per memory request, and no other request is issued before the fill returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request; taken when req_ready is high |
| req_waddr | input | 29 | Word address (byte address bits [30:2]) |
| req_ready | output | 1 | Block is idle and takes a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | One-cycle line request to next-level memory |
| mem_req_laddr | output | 27 | Line address of the request |
| mem_fill_valid | input | 1 | One-cycle strobe: line data is present |
| mem_fill_data | input | 128 | Returned line, word 0 in the low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_vb_en | input | 1 | Buffer enable value written by cfg_we |
| cnt_cache_hit | output | 16 | Cache hit count |
| cnt_vb_hit | output | 16 | Buffer hit count |
| cnt_mem | output | 16 | Memory request count |

## Verification
The main lookup is exercised with several access patterns:
- **Repeated same-line accesses** separate a plain hit from a miss.
- **Two lines fighting over one index**, accessed alternately, show that a displaced line comes back through the buffer and that the swap leaves the other line in the buffer.
- **Five conflicting lines on a second index** overflow the four-entry buffer. The older line that then misses shows that the oldest entry was replaced, while newer entries still hit.
- **A disable, re-enable sequence** shows several things. Entries held before the disable are gone. Lines displaced while disabled were never kept. A miss costs one cycle less while disabled. The buffer works again once re-enabled.

Every response is compared word by word against a line pattern derived from the address. A swap that returns the wrong entry shows up as wrong data, not only as wrong timing.

// File: rtl/cvb_pkg.sv
package cvb_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VBCHK = 2'd1,
        ST_WAIT  = 2'd2
    } cvb_state_e;

    // one pulse per counted event, packed so it maps onto the counter bank
    typedef struct packed {
        logic mem_req;
        logic vb_hit;
        logic cache_hit;
    } cvb_events_t;

    localparam int NUM_EVENTS = $bits(cvb_events_t);

endpackage

// File: rtl/cvb_dm_array.sv
module cvb_dm_array #(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 18,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int N_LINES = 1 << IDX_W;

    logic [N_LINES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [N_LINES];
    logic [LINE_W-1:0]  line_q [N_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/cvb_victim_buf.sv
module cvb_victim_buf #(
    parameter int DEPTH   = 4,
    parameter int LADDR_W = 27,
    parameter int LINE_W  = 128,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    // associative search
    input  logic [LADDR_W-1:0] lk_laddr,
    output logic               lk_hit,
    output logic [SLOT_W-1:0]  lk_slot,
    output logic [LINE_W-1:0]  lk_line,
    // exchange with the cache on a hit
    input  logic               swap_en,
    input  logic [SLOT_W-1:0]  swap_slot,
    input  logic               swap_valid,
    input  logic [LADDR_W-1:0] swap_laddr,
    input  logic [LINE_W-1:0]  swap_line,
    // new victim from a memory fill
    input  logic               push_en,
    input  logic [LADDR_W-1:0] push_laddr,
    input  logic [LINE_W-1:0]  push_line
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    logic [DEPTH-1:0]   vld_q;
    logic [LADDR_W-1:0] tag_q  [DEPTH];
    logic [LINE_W-1:0]  line_q [DEPTH];
    logic [SLOT_W-1:0]  ptr_q;
    logic [DEPTH-1:0]   match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(g);

        assign match[g] = vld_q[g] && (tag_q[g] == lk_laddr);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld_q[g]  <= 1'b0;
                tag_q[g]  <= '0;
                line_q[g] <= '0;
            end else if (swap_en && swap_slot == MY_SLOT) begin
                vld_q[g]  <= swap_valid;
                tag_q[g]  <= swap_laddr;
                line_q[g] <= swap_line;
            end else if (push_en && ptr_q == MY_SLOT) begin
                vld_q[g]  <= 1'b1;
                tag_q[g]  <= push_laddr;
                line_q[g] <= push_line;
            end
        end
    end

    always_comb begin
        lk_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) lk_slot = i[SLOT_W-1:0];
        end
    end

    assign lk_hit  = |match;
    assign lk_line = line_q[lk_slot];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr_q <= '0;
        end else if (push_en) begin
            ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/cvb_counters.sv
module cvb_counters #(
    parameter int N     = 3,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            inc,
    output logic [N-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (inc[g]) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cvb_cache.sv
module cvb_cache
    import cvb_pkg::*;
#(
    parameter int ADDR_W      = 31,
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 8192,
    parameter int VB_DEPTH    = 4,
    parameter int CNT_W       = 16,
    localparam int LINE_W     = LINE_BYTES * BYTE_W,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int WSEL_W     = OFF_W - 2,
    localparam int WADDR_W    = ADDR_W - 2,
    localparam int LADDR_W    = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [WADDR_W-1:0] req_waddr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_data,
    output logic               mem_req_valid,
    output logic [LADDR_W-1:0] mem_req_laddr,
    input  logic               mem_fill_valid,
    input  logic [LINE_W-1:0]  mem_fill_data,
    input  logic               cfg_we,
    input  logic               cfg_vb_en,
    output logic [CNT_W-1:0]   cnt_cache_hit,
    output logic [CNT_W-1:0]   cnt_vb_hit,
    output logic [CNT_W-1:0]   cnt_mem
);
    localparam int N_LINES = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W   = $clog2(N_LINES);
    localparam int TAG_W   = LADDR_W - IDX_W;
    localparam int SLOT_W  = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                    input logic [WSEL_W-1:0] s);
        return l[int'(s)*WORD_W +: WORD_W];
    endfunction

    cvb_state_e         state_q;
    logic [WADDR_W-1:0] addr_q;
    logic               vb_en_q;
    logic               resp_valid_q;
    logic [WORD_W-1:0]  resp_data_q;
    logic               mem_req_q;

    // address split of the request being looked at
    logic [WADDR_W-1:0] cur_addr;
    logic [LADDR_W-1:0] cur_laddr;
    logic [IDX_W-1:0]   cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [WSEL_W-1:0]  cur_wsel;

    assign cur_addr  = (state_q == ST_IDLE) ? req_waddr : addr_q;
    assign cur_laddr = cur_addr[WADDR_W-1:WSEL_W];
    assign cur_idx   = cur_laddr[IDX_W-1:0];
    assign cur_tag   = cur_laddr[LADDR_W-1:IDX_W];
    assign cur_wsel  = cur_addr[WSEL_W-1:0];

    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic              c_hit;
    logic              accept;

    logic              vb_hit;
    logic [SLOT_W-1:0] vb_slot;
    logic [LINE_W-1:0] vb_line;

    logic              do_swap;
    logic              do_fill;
    logic [LINE_W-1:0] src_line;
    logic [WORD_W-1:0] src_word;
    cvb_events_t       ev;

    assign c_hit   = rd_valid && (rd_tag == cur_tag);
    assign accept  = req_valid && (state_q == ST_IDLE);
    assign do_swap = (state_q == ST_VBCHK) && vb_hit;
    assign do_fill = (state_q == ST_WAIT) && mem_fill_valid;

    always_comb begin
        unique case (state_q)
            ST_VBCHK: src_line = vb_line;
            ST_WAIT:  src_line = mem_fill_data;
            default:  src_line = rd_line;
        endcase
    end
    assign src_word = pick_word(src_line, cur_wsel);

    cvb_dm_array #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cur_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .wr_en    (do_swap || do_fill),
        .wr_idx   (cur_idx),
        .wr_tag   (cur_tag),
        .wr_line  (do_swap ? vb_line : mem_fill_data)
    );

    cvb_victim_buf #(
        .DEPTH   (VB_DEPTH),
        .LADDR_W (LADDR_W),
        .LINE_W  (LINE_W)
    ) u_vbuf (
        .clk        (clk),
        .rst        (rst),
        .flush      (cfg_we && !cfg_vb_en),
        .lk_laddr   (cur_laddr),
        .lk_hit     (vb_hit),
        .lk_slot    (vb_slot),
        .lk_line    (vb_line),
        .swap_en    (do_swap),
        .swap_slot  (vb_slot),
        .swap_valid (rd_valid),
        .swap_laddr ({rd_tag, cur_idx}),
        .swap_line  (rd_line),
        .push_en    (do_fill && rd_valid && vb_en_q),
        .push_laddr ({rd_tag, cur_idx}),
        .push_line  (rd_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            vb_en_q      <= 1'b1;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            mem_req_q    <= 1'b0;
        end else begin
            resp_valid_q <= 1'b0;
            mem_req_q    <= 1'b0;
            if (cfg_we) vb_en_q <= cfg_vb_en;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_waddr;
                        if (c_hit) begin
                            resp_valid_q <= 1'b1;
                            resp_data_q  <= src_word;
                        end else if (vb_en_q) begin
                            state_q <= ST_VBCHK;
                        end else begin
                            mem_req_q <= 1'b1;
                            state_q   <= ST_WAIT;
                        end
                    end
                end
                ST_VBCHK: begin
                    if (vb_hit) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= src_word;
                        state_q      <= ST_IDLE;
                    end else begin
                        mem_req_q <= 1'b1;
                        state_q   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_fill_valid) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= src_word;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ev.cache_hit = accept && c_hit;
    assign ev.vb_hit    = do_swap;
    assign ev.mem_req   = (accept && !c_hit && !vb_en_q) ||
                          ((state_q == ST_VBCHK) && !vb_hit);

    logic [NUM_EVENTS-1:0][CNT_W-1:0] cnt_bank;

    cvb_counters #(
        .N     (NUM_EVENTS),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (ev),
        .cnt (cnt_bank)
    );

    assign cnt_cache_hit = cnt_bank[0];
    assign cnt_vb_hit    = cnt_bank[1];
    assign cnt_mem       = cnt_bank[2];

    assign req_ready     = (state_q == ST_IDLE);
    assign resp_valid    = resp_valid_q;
    assign resp_data     = resp_data_q;
    assign mem_req_valid = mem_req_q;
    assign mem_req_laddr = addr_q[WADDR_W-1:WSEL_W];

endmodule

// File: rtl/cvb_cache_chk.sv
module cvb_cache_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             mem_req_valid,
    input logic             mem_fill_valid,
    input logic             c_hit,
    input logic             vb_en_q,
    input logic [CNT_W-1:0] cnt_cache_hit,
    input logic [CNT_W-1:0] cnt_mem
);
    // R2: a hit answers in the next cycle and stays ready
    p_hit_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && c_hit) |=> (resp_valid && req_ready));

    // R2: a hit never reaches memory
    p_hit_nomem_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && c_hit) |=> !mem_req_valid);

    // R3: enabled miss spends one cycle on the buffer search first
    p_vb_search_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !c_hit && vb_en_q) |=>
        (!mem_req_valid && !resp_valid && !req_ready));

    // R4: disabled miss requests memory straight away
    p_skip_search_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !c_hit && !vb_en_q) |=> mem_req_valid);

    // R3: fill completes the access in the following cycle
    p_fill_resp_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_fill_valid && !req_ready && !mem_req_valid) |=> (resp_valid && req_ready));

    // R13: memory request lasts one cycle
    p_mem_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R11: not ready while memory is being asked
    p_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R10: memory counter steps with each request
    p_cnt_mem_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (cnt_mem == $past(cnt_mem) + 1'b1));

    // R10: hit counter steps with each hit
    p_cnt_hit_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && c_hit) |=>
        (cnt_cache_hit == $past(cnt_cache_hit) + 1'b1));

endmodule

bind cvb_cache cvb_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_fill_valid (mem_fill_valid),
    .c_hit          (c_hit),
    .vb_en_q        (vb_en_q),
    .cnt_cache_hit  (cnt_cache_hit),
    .cnt_mem        (cnt_mem)
);

// File: tb/cvb_cache_tb_top.sv
module cvb_cache_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MEM_LAT = 19;
    localparam int CNT_W   = 16;
    localparam int K_HIT = 0, K_VB = 1, K_MISS = 2;
    localparam int C_NONE = 0, C_ON = 1, C_OFF = 2;

    typedef struct packed {
        logic [30:0] addr;
        logic [1:0]  cfg;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 19;
    // index 0x10 lines: 0x100 / 0x2100 ; index 0x20 lines: 0x200 + k*0x2000
    localparam vec_t VECS [NV] = '{
        '{31'h0000100, 2'd0, 2'd2},   // A cold miss              R3
        '{31'h0000104, 2'd0, 2'd0},   // A word1 hit              R2 R12
        '{31'h0002108, 2'd0, 2'd2},   // B miss, A to buffer      R6
        '{31'h000010C, 2'd0, 2'd1},   // A back from buffer       R5
        '{31'h0000100, 2'd0, 2'd0},   // A now resident           R5
        '{31'h0002104, 2'd0, 2'd1},   // B found in freed slot    R5
        '{31'h0000200, 2'd0, 2'd2},   // X0
        '{31'h0002200, 2'd0, 2'd2},   // X1
        '{31'h0004200, 2'd0, 2'd2},   // X2
        '{31'h0006200, 2'd0, 2'd2},   // X3
        '{31'h0008200, 2'd0, 2'd2},   // X4, A overwritten        R7
        '{31'h0000208, 2'd0, 2'd1},   // X0 still buffered        R7
        '{31'h0000100, 2'd0, 2'd2},   // A was oldest, gone       R7
        '{31'h0002204, 2'd0, 2'd1},   // X1 still buffered        R7
        '{31'h0000200, 2'd2, 2'd2},   // disable: X0 flushed      R8 R4
        '{31'h0004200, 2'd0, 2'd2},   // X2 flushed               R8
        '{31'h0004204, 2'd0, 2'd0},   // hit while disabled       R2
        '{31'h0000200, 2'd1, 2'd2},   // X0 dropped when disabled R9
        '{31'h000420C, 2'd0, 2'd1}    // buffer back in service   R6
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [28:0]  req_waddr;
    logic         req_ready;
    logic         resp_valid;
    logic [31:0]  resp_data;
    logic         mem_req_valid;
    logic [26:0]  mem_req_laddr;
    logic         mem_fill_valid;
    logic [127:0] mem_fill_data;
    logic         cfg_we;
    logic         cfg_vb_en;
    logic [CNT_W-1:0] cnt_cache_hit, cnt_vb_hit, cnt_mem;

    int n_chk  = 0;
    int n_fail = 0;

    cvb_cache dut_i (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_waddr      (req_waddr),
        .req_ready      (req_ready),
        .resp_valid     (resp_valid),
        .resp_data      (resp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_laddr  (mem_req_laddr),
        .mem_fill_valid (mem_fill_valid),
        .mem_fill_data  (mem_fill_data),
        .cfg_we         (cfg_we),
        .cfg_vb_en      (cfg_vb_en),
        .cnt_cache_hit  (cnt_cache_hit),
        .cnt_vb_hit     (cnt_vb_hit),
        .cnt_mem        (cnt_mem)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [30:0] a);
        return {3'b101, a[30:4], a[3:2]};
    endfunction

    function automatic logic [127:0] mk_line(input logic [26:0] la);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = {3'b101, la, 2'(w)};
        return l;
    endfunction

    // fixed-latency next-level memory
    int          pend = 0;
    logic [26:0] m_laddr = '0;
    always @(negedge clk) begin
        mem_fill_valid = 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                mem_fill_valid = 1'b1;
                mem_fill_data  = mk_line(m_laddr);
            end
        end
        if (mem_req_valid) begin
            pend    = MEM_LAT;
            m_laddr = mem_req_laddr;
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic set_cfg(input logic en);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_vb_en = en;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run_req(input logic [30:0] a, input int exp_lat, input int exp_mat,
                           input string rq);
        int          lat;
        int          mreq_n;
        int          mreq_at;
        logic [26:0] maddr;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);
        req_valid = 1'b1;
        req_waddr = a[30:2];
        lat = 0; mreq_n = 0; mreq_at = 0; maddr = '0;
        do begin
            @(negedge clk);
            if (lat == 0) req_valid = 1'b0;
            lat++;
            if (mem_req_valid) begin
                mreq_n++;
                mreq_at = lat;
                maddr   = mem_req_laddr;
            end
            if (lat == 1 && exp_lat > 1)
                chk(req_ready == 1'b0, "R11 busy during miss", req_ready, 0);
        end while (!resp_valid && lat < 60);
        chk(lat == exp_lat, rq, lat, exp_lat);
        chk(resp_data == exp_word(a), "R12 word data", resp_data, exp_word(a));
        chk(mreq_n == ((exp_mat > 0) ? 1 : 0), "R13 memory requests", mreq_n,
            (exp_mat > 0) ? 1 : 0);
        if (exp_mat > 0) begin
            chk(mreq_at == exp_mat, "R3/R4 request cycle", mreq_at, exp_mat);
            chk(maddr == a[30:4], "R3 request line address", maddr, a[30:4]);
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit en;
        int e_hit, e_vb, e_mem;
        int exp_lat, exp_mat;
        string rq;
        rst = 1'b1; req_valid = 1'b0; req_waddr = '0;
        cfg_we = 1'b0; cfg_vb_en = 1'b0; mem_fill_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1,     "R1 ready",       req_ready, 1);
        chk(resp_valid == 1'b0,    "R1 resp_valid",  resp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req",     mem_req_valid, 0);
        chk(cnt_cache_hit == 0 && cnt_vb_hit == 0 && cnt_mem == 0, "R1 counters",
            cnt_cache_hit + cnt_vb_hit + cnt_mem, 0);

        en = 1'b1; e_hit = 0; e_vb = 0; e_mem = 0;
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].cfg == 2'(C_ON))  begin set_cfg(1'b1); en = 1'b1; end
            if (VECS[i].cfg == 2'(C_OFF)) begin set_cfg(1'b0); en = 1'b0; end
            case (int'(VECS[i].kind))
                K_HIT: begin exp_lat = 1; exp_mat = 0; rq = "R2 hit latency"; e_hit++; end
                K_VB:  begin exp_lat = 2; exp_mat = 0; rq = "R5 buffer hit latency"; e_vb++; end
                default: begin
                    exp_lat = en ? MEM_LAT + 3 : MEM_LAT + 2;
                    exp_mat = en ? 2 : 1;
                    rq = en ? "R3/R6/R7/R9 enabled miss latency" : "R4/R8 disabled miss latency";
                    e_mem++;
                end
            endcase
            run_req(VECS[i].addr, exp_lat, exp_mat, rq);
        end

        @(negedge clk);
        chk(cnt_cache_hit == CNT_W'(e_hit), "R10 cache hit count", cnt_cache_hit, e_hit);
        chk(cnt_vb_hit == CNT_W'(e_vb),     "R10 buffer hit count", cnt_vb_hit, e_vb);
        chk(cnt_mem == CNT_W'(e_mem),       "R10 memory count", cnt_mem, e_mem);

        // R1: reset restores enable, clears counters and empties the cache
        set_cfg(1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cnt_cache_hit == 0 && cnt_vb_hit == 0 && cnt_mem == 0, "R1 counters after reset",
            cnt_cache_hit + cnt_vb_hit + cnt_mem, 0);
        run_req(31'h0004200, MEM_LAT + 3, 2, "R1 enabled after reset");

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule